// File: doc/BRIEF.md
# Dual-Master Address Decode Router

This block sits between two read masters of a console-style main processor and two storage backends. An instruction-fetch port issues 32-bit virtual addresses. A DMA read-master port issues physical addresses and takes 128-bit data. The router turns each fetch address into a physical address by removing the kernel-segment alias. It checks that address against the boot-ROM window, and it checks each DMA address against the main-RAM window. A request that hits its window is forwarded to its backend as a byte offset from the window base, aligned for that backend.

Both backends answer one cycle after a request. The router returns the answer to the port that asked and marks it valid in that same cycle. An address outside the port's window is never forwarded. It completes one cycle later with zero data and an error flag. Each successful access also produces a trace event on a lane of its own (lane 0 for fetch, lane 1 for DMA). The event is tagged with a master id and a region id, so that a trace collector can tell who touched what.

Top module: `ar_router`

## Requirements
- R1: While reset is applied, and after it is released with no request, if_valid, if_error, dma_valid, dma_error and both trc_valid bits are 0.
- R2: A fetch address whose bits [31:30] are 2'b10 (kseg0 0x80000000-0x9FFFFFFF or kseg1 0xA0000000-0xBFFFFFFF) has its top three bits cleared. A physical address in 0x1FC00000-0x1FFFFFFF hits the boot ROM. rom_rd_en is then raised in the same cycle with rom_rd_addr = physical - 0x1FC00000 and bits [1:0] forced to 0, so 0xBFC00000 reads offset 0.
- R3: A fetch address whose bits [31:30] are not 2'b10 is used unchanged as the physical address. For example, 0x1FC00010 reads offset 0x10, and 0xDFC00000 misses.
- R4: A fetch that misses the boot-ROM window raises no rom_rd_en. In the next cycle it gives if_valid=1, if_error=1 and if_rdata=0.
- R5: A DMA address below 0x02000000 raises ram_rd_en in the same cycle with ram_rd_addr = address[24:0] and bits [3:0] forced to 0.
- R6: A DMA address of 0x02000000 or above raises no ram_rd_en. In the next cycle it gives dma_valid=1, dma_error=1 and dma_rdata=0.
- R7: A request accepted in cycle N gives valid in cycle N+1 and no valid in other cycles. On a hit, error is 0 and the read data equals the backend's data for that offset, which the backend presents in cycle N+1.
- R8: Fetch and DMA requests in the same cycle proceed independently, and each port receives only its own result.
- R9: A hit produces, in the cycle of its valid, a trace event on lane L (0 = fetch, 1 = DMA). The fields are: trc_valid[L]=1; trc_addr[32L+:32] = the request address as issued; trc_data[64L+:64] = the low 64 bits of the read data, zero-extended for fetch; trc_master[8L+:8] = 0 for fetch and 1 for DMA; trc_region[8L+:8] = 0 for boot ROM and 1 for main RAM; trc_flags[8L+:8] = 0, since bit 0 marks a write and all accesses are reads. A miss produces no trace event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_req | input | 1 | Fetch request strobe |
| if_addr | input | 32 | Fetch virtual address |
| if_valid | output | 1 | Fetch result valid |
| if_error | output | 1 | Fetch address was outside the boot ROM |
| if_rdata | output | 32 | Fetch read data |
| dma_req | input | 1 | DMA read request strobe |
| dma_addr | input | 32 | DMA physical address |
| dma_valid | output | 1 | DMA result valid |
| dma_error | output | 1 | DMA address was outside main RAM |
| dma_rdata | output | 128 | DMA read data |
| rom_rd_en | output | 1 | Boot-ROM read strobe |
| rom_rd_addr | output | 22 | Boot-ROM byte offset, word aligned |
| rom_rd_data | input | 32 | Boot-ROM data, one cycle after the strobe |
| ram_rd_en | output | 1 | Main-RAM read strobe |
| ram_rd_addr | output | 25 | Main-RAM byte offset, 16-byte aligned |
| ram_rd_data | input | 128 | Main-RAM data, one cycle after the strobe |
| trc_valid | output | 2 | Trace event valid per lane |
| trc_addr | output | 64 | Trace request address, 32 bits per lane |
| trc_data | output | 128 | Trace low data bits, 64 bits per lane |
| trc_master | output | 16 | Trace master id, 8 bits per lane |
| trc_region | output | 16 | Trace region id, 8 bits per lane |
| trc_flags | output | 16 | Trace flags, 8 bits per lane |

## Verification
The assertions assume that reset is held from time zero, and that no request is asserted while reset is applied or in the first cycle after its release. The latency and history properties look one cycle back, so they depend on this. They also assume that each backend presents its data exactly one cycle after its strobe. The bench keeps both request strobes low during reset and models both backends as registered read functions with that latency. It drives every input half a cycle away from the sampling edge.

// File: rtl/ar_pkg.sv
package ar_pkg;

    localparam int unsigned VA_W = 32;

    localparam logic [VA_W-1:0] ROM_PHYS_BASE = 32'h1FC0_0000;
    localparam logic [VA_W-1:0] RAM_PHYS_BASE = 32'h0000_0000;

    typedef enum logic [7:0] {
        MST_FETCH = 8'd0,
        MST_DMA   = 8'd1
    } master_e;

    typedef enum logic [7:0] {
        RGN_BOOTROM = 8'd0,
        RGN_MAINRAM = 8'd1
    } region_e;

    localparam logic [7:0] TRC_FLAG_WRITE = 8'h01;

    // Kernel segments 0 and 1 alias physical memory through the low 29 bits.
    function automatic logic [VA_W-1:0] strip_kseg(input logic [VA_W-1:0] va);
        logic [VA_W-1:0] pa;
        if (va[31:30] == 2'b10) pa = {3'b000, va[28:0]};
        else                    pa = va;
        return pa;
    endfunction

endpackage : ar_pkg

// File: rtl/ar_window_decode.sv
module ar_window_decode
    import ar_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h0,
    parameter int unsigned BYTES     = 1024,
    parameter int unsigned ALIGN     = 2,
    parameter bit          STRIP_SEG = 1'b0,
    localparam int unsigned AW       = $clog2(BYTES)
) (
    input  logic [VA_W-1:0] addr,
    output logic            hit,
    output logic [AW-1:0]   offset
);

    logic [VA_W-1:0] phys;
    logic [VA_W:0]   diff;
    logic [AW-1:0]   align_mask;

    generate
        if (STRIP_SEG) begin : g_strip
            assign phys = strip_kseg(addr);
        end else begin : g_pass
            assign phys = addr;
        end
    endgenerate

    // Borrow lands in bit VA_W when phys < BASE; any bit at or above AW means out of window.
    assign diff       = {1'b0, phys} - {1'b0, BASE};
    assign hit        = (diff[VA_W:AW] == '0);
    assign align_mask = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};
    assign offset     = diff[AW-1:0] & align_mask;

endmodule : ar_window_decode

// File: rtl/ar_return_lane.sv
module ar_return_lane
    import ar_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter master_e     MASTER = MST_FETCH,
    parameter region_e     REGION = RGN_BOOTROM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              hit,
    input  logic [VA_W-1:0]   req_addr,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              valid,
    output logic              error,
    output logic [DATA_W-1:0] rdata,
    output logic              trc_valid,
    output logic [VA_W-1:0]   trc_addr,
    output logic [63:0]       trc_data,
    output logic [7:0]        trc_master,
    output logic [7:0]        trc_region,
    output logic [7:0]        trc_flags
);

    logic            pend_ok;
    logic            pend_err;
    logic [VA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ok  <= 1'b0;
            pend_err <= 1'b0;
            addr_q   <= '0;
        end else begin
            pend_ok  <= req & hit;
            pend_err <= req & ~hit;
            if (req) addr_q <= req_addr;
        end
    end

    assign valid = pend_ok | pend_err;
    assign error = pend_err;
    assign rdata = pend_ok ? be_rdata : '0;

    assign trc_valid  = pend_ok;
    assign trc_addr   = addr_q;
    assign trc_master = MASTER;
    assign trc_region = REGION;
    assign trc_flags  = TRC_FLAG_WRITE & 8'h00;

    generate
        if (DATA_W >= 64) begin : g_wide
            assign trc_data = rdata[63:0];
        end else begin : g_narrow
            assign trc_data = {{(64-DATA_W){1'b0}}, rdata};
        end
    endgenerate

endmodule : ar_return_lane

// File: rtl/ar_router.sv
module ar_router
    import ar_pkg::*;
#(
    parameter int unsigned ROM_BYTES  = 4 * 1024 * 1024,
    parameter int unsigned RAM_BYTES  = 32 * 1024 * 1024,
    parameter int unsigned ROM_DATA_W = 32,
    parameter int unsigned RAM_DATA_W = 128,
    localparam int unsigned ROM_AW    = $clog2(ROM_BYTES),
    localparam int unsigned RAM_AW    = $clog2(RAM_BYTES),
    localparam int unsigned ROM_ALIGN = $clog2(ROM_DATA_W / 8),
    localparam int unsigned RAM_ALIGN = $clog2(RAM_DATA_W / 8)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  if_req,
    input  logic [31:0]           if_addr,
    output logic                  if_valid,
    output logic                  if_error,
    output logic [ROM_DATA_W-1:0] if_rdata,
    input  logic                  dma_req,
    input  logic [31:0]           dma_addr,
    output logic                  dma_valid,
    output logic                  dma_error,
    output logic [RAM_DATA_W-1:0] dma_rdata,
    output logic                  rom_rd_en,
    output logic [ROM_AW-1:0]     rom_rd_addr,
    input  logic [ROM_DATA_W-1:0] rom_rd_data,
    output logic                  ram_rd_en,
    output logic [RAM_AW-1:0]     ram_rd_addr,
    input  logic [RAM_DATA_W-1:0] ram_rd_data,
    output logic [1:0]            trc_valid,
    output logic [63:0]           trc_addr,
    output logic [127:0]          trc_data,
    output logic [15:0]           trc_master,
    output logic [15:0]           trc_region,
    output logic [15:0]           trc_flags
);

    logic if_hit;
    logic dma_hit;

    ar_window_decode #(
        .BASE(ROM_PHYS_BASE), .BYTES(ROM_BYTES), .ALIGN(ROM_ALIGN), .STRIP_SEG(1'b1)
    ) u_if_dec (
        .addr(if_addr), .hit(if_hit), .offset(rom_rd_addr)
    );

    ar_window_decode #(
        .BASE(RAM_PHYS_BASE), .BYTES(RAM_BYTES), .ALIGN(RAM_ALIGN), .STRIP_SEG(1'b0)
    ) u_dma_dec (
        .addr(dma_addr), .hit(dma_hit), .offset(ram_rd_addr)
    );

    assign rom_rd_en = if_req & if_hit;
    assign ram_rd_en = dma_req & dma_hit;

    ar_return_lane #(
        .DATA_W(ROM_DATA_W), .MASTER(MST_FETCH), .REGION(RGN_BOOTROM)
    ) u_if_lane (
        .clk(clk), .rst(rst), .req(if_req), .hit(if_hit), .req_addr(if_addr),
        .be_rdata(rom_rd_data), .valid(if_valid), .error(if_error), .rdata(if_rdata),
        .trc_valid(trc_valid[0]), .trc_addr(trc_addr[31:0]), .trc_data(trc_data[63:0]),
        .trc_master(trc_master[7:0]), .trc_region(trc_region[7:0]), .trc_flags(trc_flags[7:0])
    );

    ar_return_lane #(
        .DATA_W(RAM_DATA_W), .MASTER(MST_DMA), .REGION(RGN_MAINRAM)
    ) u_dma_lane (
        .clk(clk), .rst(rst), .req(dma_req), .hit(dma_hit), .req_addr(dma_addr),
        .be_rdata(ram_rd_data), .valid(dma_valid), .error(dma_error), .rdata(dma_rdata),
        .trc_valid(trc_valid[1]), .trc_addr(trc_addr[63:32]), .trc_data(trc_data[127:64]),
        .trc_master(trc_master[15:8]), .trc_region(trc_region[15:8]), .trc_flags(trc_flags[15:8])
    );

endmodule : ar_router

// File: rtl/ar_router_chk.sv
module ar_router_chk #(
    parameter int unsigned ROM_BYTES  = 4 * 1024 * 1024,
    parameter int unsigned RAM_BYTES  = 32 * 1024 * 1024,
    parameter int unsigned ROM_DATA_W = 32,
    localparam int unsigned ROM_AW    = $clog2(ROM_BYTES),
    localparam int unsigned RAM_AW    = $clog2(RAM_BYTES)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  if_req,
    input logic [31:0]           if_addr,
    input logic                  if_valid,
    input logic                  if_error,
    input logic [ROM_DATA_W-1:0] if_rdata,
    input logic                  dma_req,
    input logic [31:0]           dma_addr,
    input logic                  dma_valid,
    input logic                  dma_error,
    input logic                  rom_rd_en,
    input logic [ROM_AW-1:0]     rom_rd_addr,
    input logic                  ram_rd_en,
    input logic [RAM_AW-1:0]     ram_rd_addr,
    input logic [1:0]            trc_valid,
    input logic [63:0]           trc_addr
);

    AST_ROM_ONLY_ON_FETCH: assert property (@(posedge clk) disable iff (rst) rom_rd_en |-> if_req); // R4
    AST_ROM_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst) rom_rd_en |-> (rom_rd_addr[1:0] == 2'b00)); // R2
    AST_RAM_QWORD_ALIGN: assert property (@(posedge clk) disable iff (rst) ram_rd_en |-> (ram_rd_addr[3:0] == 4'h0)); // R5
    AST_RAM_ONLY_ON_DMA: assert property (@(posedge clk) disable iff (rst) ram_rd_en |-> dma_req); // R6
    AST_IF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) if_req |=> if_valid); // R7
    AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) dma_req |=> dma_valid); // R7
    AST_IF_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst) if_valid |-> $past(if_req)); // R7
    AST_DMA_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst) dma_valid |-> $past(dma_req)); // R8
    AST_IF_MISS_ERROR: assert property (@(posedge clk) disable iff (rst) (if_req && !rom_rd_en) |=> if_error); // R4
    AST_DMA_MISS_ERROR: assert property (@(posedge clk) disable iff (rst) (dma_req && !ram_rd_en) |=> dma_error); // R6
    AST_IF_ERROR_ZERO: assert property (@(posedge clk) disable iff (rst) if_error |-> (if_rdata == '0)); // R4
    AST_TRC_IF_ADDR: assert property (@(posedge clk) disable iff (rst) trc_valid[0] |-> (trc_addr[31:0] == $past(if_addr))); // R9
    AST_TRC_DMA_ADDR: assert property (@(posedge clk) disable iff (rst) trc_valid[1] |-> (trc_addr[63:32] == $past(dma_addr))); // R9
    AST_TRC_NOT_ON_ERROR: assert property (@(posedge clk) disable iff (rst) (trc_valid[1] || dma_error) |-> !(trc_valid[1] && dma_error)); // R9

endmodule : ar_router_chk

bind ar_router ar_router_chk #(
    .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES), .ROM_DATA_W(ROM_DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .if_req(if_req), .if_addr(if_addr), .if_valid(if_valid),
    .if_error(if_error), .if_rdata(if_rdata), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_valid(dma_valid), .dma_error(dma_error), .rom_rd_en(rom_rd_en),
    .rom_rd_addr(rom_rd_addr), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .trc_valid(trc_valid), .trc_addr(trc_addr)
);

// File: tb/ar_router_tb.sv
`timescale 1ns/1ps
module ar_router_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         if_req = 1'b0;
    logic [31:0]  if_addr = '0;
    logic         if_valid, if_error;
    logic [31:0]  if_rdata;
    logic         dma_req = 1'b0;
    logic [31:0]  dma_addr = '0;
    logic         dma_valid, dma_error;
    logic [127:0] dma_rdata;
    logic         rom_rd_en;
    logic [21:0]  rom_rd_addr;
    logic [31:0]  rom_rd_data;
    logic         ram_rd_en;
    logic [24:0]  ram_rd_addr;
    logic [127:0] ram_rd_data;
    logic [1:0]   trc_valid;
    logic [63:0]  trc_addr;
    logic [127:0] trc_data;
    logic [15:0]  trc_master, trc_region, trc_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ar_router u_dut (
        .clk(clk), .rst(rst),
        .if_req(if_req), .if_addr(if_addr), .if_valid(if_valid), .if_error(if_error), .if_rdata(if_rdata),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_valid(dma_valid), .dma_error(dma_error), .dma_rdata(dma_rdata),
        .rom_rd_en(rom_rd_en), .rom_rd_addr(rom_rd_addr), .rom_rd_data(rom_rd_data),
        .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .trc_valid(trc_valid), .trc_addr(trc_addr), .trc_data(trc_data),
        .trc_master(trc_master), .trc_region(trc_region), .trc_flags(trc_flags)
    );

    function automatic logic [31:0] rom_fn(input logic [21:0] off);
        return {10'h0, off} * 32'h0001_0003 + 32'h5A5A_0000;
    endfunction

    function automatic logic [127:0] ram_fn(input logic [24:0] off);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = {7'h0, off} * 32'd7 + i * 32'h1111_1111;
        return v;
    endfunction

    // Behavioural backends, one-cycle latency
    logic [31:0]  rom_q = '0;
    logic [127:0] ram_q = '0;
    always_ff @(posedge clk) begin
        if (rom_rd_en) rom_q <= rom_fn(rom_rd_addr);
        if (ram_rd_en) ram_q <= ram_fn(ram_rd_addr);
    end
    assign rom_rd_data = rom_q;
    assign ram_rd_data = ram_q;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic exp_fetch(input logic [31:0] a, output logic hit, output logic [21:0] off);
        logic [31:0] pa;
        pa  = (a[31:30] == 2'b10) ? (a & 32'h1FFF_FFFF) : a;
        hit = (pa >= 32'h1FC0_0000) && (pa <= 32'h1FFF_FFFF);
        off = 22'((pa - 32'h1FC0_0000) & 32'hFFFF_FFFC);
    endtask

    task automatic exp_dma(input logic [31:0] a, output logic hit, output logic [24:0] off);
        hit = (a < 32'h0200_0000);
        off = 25'(a & 32'h01FF_FFF0);
    endtask

    // state of the request issued in the previous cycle
    logic        p_freq = 0, p_fhit = 0, p_dreq = 0, p_dhit = 0;
    logic [31:0] p_fa = 0, p_da = 0;
    logic [21:0] p_foff = 0;
    logic [24:0] p_doff = 0;

    task automatic check_results();
        string ft, dt;
        logic [31:0]  fexp;
        logic [127:0] dexp;
        ft = p_fhit ? "R7" : "R4";
        dt = p_dhit ? "R7" : "R6";
        fexp = p_fhit ? rom_fn(p_foff) : 32'h0;
        dexp = p_dhit ? ram_fn(p_doff) : 128'h0;
        chk("R7 if_valid", 128'(if_valid), 128'(p_freq));
        chk("R7 dma_valid", 128'(dma_valid), 128'(p_dreq));
        if (p_freq && p_dreq) chk("R8 both valid", 128'({if_valid, dma_valid}), 128'(2'b11));
        if (p_freq) begin
            chk({ft, " if_error"}, 128'(if_error), 128'(!p_fhit));
            chk({ft, " if_rdata"}, 128'(if_rdata), 128'(fexp));
        end else chk("R8 if_error idle", 128'(if_error), 128'(0));
        if (p_dreq) begin
            chk({dt, " dma_error"}, 128'(dma_error), 128'(!p_dhit));
            chk({dt, " dma_rdata"}, dma_rdata, dexp);
        end else chk("R8 dma_error idle", 128'(dma_error), 128'(0));
        chk("R9 trc_valid", 128'(trc_valid), 128'({p_dreq && p_dhit, p_freq && p_fhit}));
        if (p_freq && p_fhit) begin
            chk("R9 fetch trace addr", 128'(trc_addr[31:0]), 128'(p_fa));
            chk("R9 fetch trace data", 128'(trc_data[63:0]), 128'({32'h0, fexp}));
            chk("R9 fetch trace tags", 128'({trc_master[7:0], trc_region[7:0], trc_flags[7:0]}), 128'(24'h000000));
        end
        if (p_dreq && p_dhit) begin
            chk("R9 dma trace addr", 128'(trc_addr[63:32]), 128'(p_da));
            chk("R9 dma trace data", 128'(trc_data[127:64]), 128'(dexp[63:0]));
            chk("R9 dma trace tags", 128'({trc_master[15:8], trc_region[15:8], trc_flags[15:8]}), 128'(24'h010100));
        end
    endtask

    task automatic issue(input logic fr, input logic [31:0] fa, input logic dr, input logic [31:0] da);
        logic        fh, dh;
        logic [21:0] fo;
        logic [24:0] dof;
        string       ftag;
        check_results();
        exp_fetch(fa, fh, fo);
        exp_dma(da, dh, dof);
        if_req = fr; if_addr = fa; dma_req = dr; dma_addr = da;
        #1;
        ftag = (fa[31:30] == 2'b10) ? "R2" : "R3";
        chk({ftag, " rom_rd_en"}, 128'(rom_rd_en), 128'(fr && fh));
        if (fr && fh) chk({ftag, " rom_rd_addr"}, 128'(rom_rd_addr), 128'(fo));
        if (fr && !fh) chk("R4 no rom forward", 128'(rom_rd_en), 128'(0));
        chk("R5 ram_rd_en", 128'(ram_rd_en), 128'(dr && dh));
        if (dr && dh) chk("R5 ram_rd_addr", 128'(ram_rd_addr), 128'(dof));
        if (dr && !dh) chk("R6 no ram forward", 128'(ram_rd_en), 128'(0));
        p_freq = fr; p_fa = fa; p_fhit = fh; p_foff = fo;
        p_dreq = dr; p_da = da; p_dhit = dh; p_doff = dof;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] segs [5];
        logic [31:0] phys [8];
        logic [31:0] dlist [8];
        logic [31:0] lcg;
        logic [2:0]  sm;
        segs  = '{32'h0000_0000, 32'h8000_0000, 32'hA000_0000, 32'hC000_0000, 32'h2000_0000};
        phys  = '{32'h1FC0_0000, 32'h1FC0_0007, 32'h1FD2_468C, 32'h1FFF_FFFC,
                  32'h1FFF_FFFF, 32'h1FBF_FFFC, 32'h0000_0000, 32'h0BFC_0000};
        dlist = '{32'h0000_0000, 32'h0000_000F, 32'h0000_0010, 32'h01FF_FFF0,
                  32'h01FF_FFFF, 32'h0200_0000, 32'h8000_0000, 32'hFFFF_FFFF};
        lcg = 32'h1234_5678;

        repeat (4) @(negedge clk);
        chk("R1 in-reset valids", 128'({if_valid, if_error, dma_valid, dma_error, trc_valid}), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after-reset valids", 128'({if_valid, if_error, dma_valid, dma_error, trc_valid}), 128'(0));
        @(negedge clk);

        // directed sweep: every segment against every physical point
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 8; p++) begin
                issue(1'b1, segs[s] | (phys[p] & 32'h1FFF_FFFF), 1'b1, dlist[(s + p) % 8]);
            end
        end
        // isolated ports and idle cycles
        for (int d = 0; d < 8; d++) begin
            issue(1'b0, 32'h0, 1'b1, dlist[d]);
            issue(1'b1, 32'hBFC0_0000 + d * 4, 1'b0, 32'h0);
            issue(1'b0, 32'h0, 1'b0, 32'h0);
        end
        // pseudo-random mixed traffic around both window edges
        for (int k = 0; k < 600; k++) begin
            logic [31:0] fa, pa, da;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pa  = 32'h1F80_0000 + (lcg & 32'h007F_FFFF);
            sm  = (lcg[31:30] == 2'd0) ? 3'b000 : (lcg[31:30] == 2'd1) ? 3'b100 :
                  (lcg[31:30] == 2'd2) ? 3'b101 : 3'b110;
            fa  = {sm, pa[28:0]};
            lcg = lcg * 32'd1103515245 + 32'd12345;
            da  = lcg & 32'h03FF_FFFF;
            issue((k % 5) != 4, fa, (k % 7) != 3, da);
        end
        issue(1'b0, 32'h0, 1'b0, 32'h0);
        check_results();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule : ar_router_tb